// File: doc/BRIEF.md
# Barrel Peripheral Processor Slot Sequencer

This block lets ten peripheral processors share a single execution datapath. Each processor keeps its own saved state: an I/O channel register and an 18-bit accumulator. A slot pointer advances once per clock in strict ascending order and wraps from the last processor back to processor 0. During its slot, the owning processor's state is read from the state file and passed through the shared datapath together with the operation presented for that slot. The result is written back at the end of the slot. At one slot per clock, a full rotation takes ten clocks. At a 100 ns slot, one rotation is one 1 us major cycle.

The channel address output always carries the channel register of the current slot owner. Deadstart, and reset, return every processor's channel register to that processor's own number, clear all accumulators and restart the rotation at processor 0. They also place processor 0 in load mode. In load mode, operations presented in slot 0 are ignored, because the processor is still taking in its program from channel 0. A disconnect pulse from the load source ends load mode, and processor 0 then runs like the others.

Top module: `bpp_slot_sequencer`

## Requirements
- R1: `slot_o` advances by one on every clock, in ascending order 0,1,…,9, and wraps from 9 back to 0.
- R2: `chan_o` and `acc_o` show the channel register and accumulator of the processor whose number is on `slot_o`, in the same cycle.
- R3: While `rst_n` is low, and in the cycle after a `deadstart_i` pulse, `slot_o` is 0 and `load_mode_o` is 1. Every processor's channel register equals its own number and every accumulator is 0.
- R4: Operation code 1 (increment channel), presented with `op_valid_i` in a slot, adds one to that slot owner's channel register. The new value appears on `chan_o` in that processor's next slot.
- R5: An operation changes only the state of the processor that owns the slot in which it is presented. Other processors' channel registers and accumulators keep their values.
- R6: While `load_mode_o` is 1, an operation presented in slot 0 has no effect. Operations in the other slots still execute.
- R7: A `load_disc_i` pulse clears `load_mode_o` in the following cycle. After that, operations in slot 0 execute.
- R8: Operation code 3 (add) adds the zero-extended 12-bit `op_imm_i` to the 18-bit accumulator modulo 2^18, so sums carry into bits 12 to 17.
- R9: Operation code 2 (zero load) clears all 18 accumulator bits, including bits 12 to 17. Code 0 is a no-operation.
- R10: Incrementing a channel register that holds 31 wraps it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock, one slot per cycle |
| rst_n | input | 1 | Active-low reset with the same effect as deadstart |
| deadstart_i | input | 1 | Synchronous deadstart pulse |
| load_disc_i | input | 1 | Load source has disconnected from channel 0 |
| op_valid_i | input | 1 | An operation is presented for the current slot |
| op_i | input | 2 | Operation code: 0 nop, 1 increment channel, 2 zero load, 3 add |
| op_imm_i | input | 12 | Immediate word for the add operation |
| slot_o | output | 4 | Processor that owns the current slot |
| chan_o | output | 5 | Channel address of the slot owner |
| acc_o | output | 18 | Accumulator of the slot owner |
| load_mode_o | output | 1 | Processor 0 is still in load mode |

## Verification
A rotation with no operations shows the plain deadstart mapping: every slot drives the channel with its own number. This separates a rotor that skips or repeats a slot from a channel mux that picks the wrong entry. An increment by processor 0 is followed by a full rotation. Only slot 0 may then show channel 1, which tells a per-processor write apart from a shared one. The same increment issued while still in load mode must leave channel 0 in place, while an increment in slot 2 takes effect. Adding an all-ones word twice carries into the upper accumulator bits, a zero load must clear those bits as well, and twenty-three increments on processor 9 exercise the channel wrap.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
    localparam int NPROC_DEF  = 10;
    localparam int CHAN_W_DEF = 5;
    localparam int ACC_W_DEF  = 18;
    localparam int WORD_W_DEF = 12;

    typedef enum logic [1:0] {
        OP_NOP      = 2'd0,
        OP_INC_CHAN = 2'd1,
        OP_ZERO     = 2'd2,
        OP_ADD      = 2'd3
    } op_e;
endpackage

// File: rtl/bpp_slot_rotor.sv
module bpp_slot_rotor #(
    parameter int NPROC = bpp_pkg::NPROC_DEF,
    localparam int SW   = $clog2(NPROC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    output logic [SW-1:0] slot_o
);
    localparam logic [SW-1:0] LAST = SW'(NPROC - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } rot_t;

    rot_t rot_d, rot_q;

    always_comb begin
        rot_d = rot_q;
        if (restart_i)
            rot_d.slot = '0;
        else if (rot_q.slot == LAST)
            rot_d.slot = '0;
        else
            rot_d.slot = rot_q.slot + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end

    assign slot_o = rot_q.slot;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rot_q.slot <= LAST);                                               // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && rot_q.slot != LAST) |=> rot_q.slot == SW'($past(rot_q.slot) + 1'b1)); // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_q.slot == LAST) |=> rot_q.slot == '0);                        // R1
    AST_RESTART_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> rot_q.slot == '0);                                   // R3
endmodule

// File: rtl/bpp_exec.sv
module bpp_exec #(
    parameter int CHAN_W = bpp_pkg::CHAN_W_DEF,
    parameter int ACC_W  = bpp_pkg::ACC_W_DEF,
    parameter int WORD_W = bpp_pkg::WORD_W_DEF
) (
    input  logic              en_i,
    input  bpp_pkg::op_e      op_i,
    input  logic [WORD_W-1:0] imm_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [ACC_W-1:0]  acc_i,
    output logic              we_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic [ACC_W-1:0]  acc_o
);
    import bpp_pkg::*;

    always_comb begin
        we_o   = 1'b0;
        chan_o = chan_i;
        acc_o  = acc_i;
        if (en_i) begin
            unique case (op_i)
                OP_INC_CHAN: begin
                    we_o   = 1'b1;
                    chan_o = chan_i + 1'b1;
                end
                OP_ZERO: begin
                    we_o  = 1'b1;
                    acc_o = '0;
                end
                OP_ADD: begin
                    we_o  = 1'b1;
                    acc_o = acc_i + ACC_W'(imm_i);
                end
                default: we_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bpp_state_file.sv
module bpp_state_file #(
    parameter int NPROC  = bpp_pkg::NPROC_DEF,
    parameter int CHAN_W = bpp_pkg::CHAN_W_DEF,
    parameter int ACC_W  = bpp_pkg::ACC_W_DEF,
    localparam int SW    = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [SW-1:0]     idx_i,
    input  logic              we_i,
    input  logic [CHAN_W-1:0] wchan_i,
    input  logic [ACC_W-1:0]  wacc_i,
    output logic [CHAN_W-1:0] rchan_o,
    output logic [ACC_W-1:0]  racc_o
);
    typedef struct packed {
        logic [NPROC-1:0][CHAN_W-1:0] chan;
        logic [NPROC-1:0][ACC_W-1:0]  acc;
    } file_t;

    file_t file_d, file_q;

    function automatic file_t deadstart_image();
        file_t f;
        for (int i = 0; i < NPROC; i++) begin
            f.chan[i] = CHAN_W'(i);
            f.acc[i]  = '0;
        end
        return f;
    endfunction

    always_comb begin
        file_d = file_q;
        if (restart_i) begin
            file_d = deadstart_image();
        end else if (we_i) begin
            file_d.chan[idx_i] = wchan_i;
            file_d.acc[idx_i]  = wacc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) file_q <= deadstart_image();
        else        file_q <= file_d;
    end

    assign rchan_o = file_q.chan[idx_i];
    assign racc_o  = file_q.acc[idx_i];

    for (genvar g = 0; g < NPROC; g++) begin : g_slot_chk
        AST_DS_OWN_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
            restart_i |=> (file_q.chan[g] == CHAN_W'(g) && file_q.acc[g] == '0)); // R3
        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart_i && !(we_i && idx_i == SW'(g))) |=>
                ($stable(file_q.chan[g]) && $stable(file_q.acc[g])));            // R5
    end
endmodule

// File: rtl/bpp_slot_sequencer.sv
module bpp_slot_sequencer #(
    parameter int NPROC  = bpp_pkg::NPROC_DEF,
    parameter int CHAN_W = bpp_pkg::CHAN_W_DEF,
    parameter int ACC_W  = bpp_pkg::ACC_W_DEF,
    parameter int WORD_W = bpp_pkg::WORD_W_DEF,
    localparam int SW    = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deadstart_i,
    input  logic              load_disc_i,
    input  logic              op_valid_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] op_imm_i,
    output logic [SW-1:0]     slot_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic              load_mode_o
);
    import bpp_pkg::*;

    typedef struct packed {
        logic load_mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SW-1:0]     slot;
    logic [CHAN_W-1:0] cur_chan, nxt_chan;
    logic [ACC_W-1:0]  cur_acc, nxt_acc;
    logic              exec_en, wr_en;
    op_e               op;

    assign op = op_e'(op_i);

    always_comb begin
        ctl_d = ctl_q;
        if (deadstart_i)      ctl_d.load_mode = 1'b1;
        else if (load_disc_i) ctl_d.load_mode = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{load_mode: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign exec_en = op_valid_i && !deadstart_i && !(ctl_q.load_mode && slot == '0);

    bpp_slot_rotor #(.NPROC(NPROC)) u_rotor (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (deadstart_i),
        .slot_o    (slot)
    );

    bpp_state_file #(.NPROC(NPROC), .CHAN_W(CHAN_W), .ACC_W(ACC_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (deadstart_i),
        .idx_i     (slot),
        .we_i      (wr_en),
        .wchan_i   (nxt_chan),
        .wacc_i    (nxt_acc),
        .rchan_o   (cur_chan),
        .racc_o    (cur_acc)
    );

    bpp_exec #(.CHAN_W(CHAN_W), .ACC_W(ACC_W), .WORD_W(WORD_W)) u_exec (
        .en_i   (exec_en),
        .op_i   (op),
        .imm_i  (op_imm_i),
        .chan_i (cur_chan),
        .acc_i  (cur_acc),
        .we_o   (wr_en),
        .chan_o (nxt_chan),
        .acc_o  (nxt_acc)
    );

    assign slot_o      = slot;
    assign chan_o      = cur_chan;
    assign acc_o       = cur_acc;
    assign load_mode_o = ctl_q.load_mode;

    AST_LOAD_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.load_mode && slot == '0) |-> !wr_en);                         // R6
    AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_disc_i && !deadstart_i) |=> !ctl_q.load_mode);                  // R7
    AST_DS_LOADMODE: assert property (@(posedge clk) disable iff (!rst_n)
        deadstart_i |=> ctl_q.load_mode);                                    // R3
    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_INC_CHAN) |-> (nxt_chan == CHAN_W'(cur_chan + 1'b1) && nxt_acc == cur_acc)); // R4
    AST_ZERO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_ZERO) |-> nxt_acc == '0);                         // R9
endmodule

// File: tb/tb_bpp_slot_sequencer.sv
module tb_bpp_slot_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deadstart_i = 1'b0;
    logic        load_disc_i = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [11:0] op_imm_i = '0;
    logic [3:0]  slot_o;
    logic [4:0]  chan_o;
    logic [17:0] acc_o;
    logic        load_mode_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bpp_slot_sequencer dut (
        .clk(clk), .rst_n(rst_n), .deadstart_i(deadstart_i), .load_disc_i(load_disc_i),
        .op_valid_i(op_valid_i), .op_i(op_i), .op_imm_i(op_imm_i),
        .slot_o(slot_o), .chan_o(chan_o), .acc_o(acc_o), .load_mode_o(load_mode_o)
    );

    typedef struct packed {
        logic [3:0] slot;
        logic [4:0] chan;
    } vec_t;

    localparam vec_t ROT_VEC [12] = '{
        '{4'd1, 5'd1}, '{4'd2, 5'd2}, '{4'd3, 5'd3}, '{4'd4, 5'd4},
        '{4'd5, 5'd5}, '{4'd6, 5'd6}, '{4'd7, 5'd7}, '{4'd8, 5'd8},
        '{4'd9, 5'd9}, '{4'd0, 5'd0}, '{4'd1, 5'd1}, '{4'd2, 5'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_slot(input int k);
        while (int'(slot_o) != k) @(negedge clk);
    endtask

    task automatic issue(input int k, input logic [1:0] code, input logic [11:0] imm);
        go_slot(k);
        op_valid_i = 1'b1;
        op_i       = code;
        op_imm_i   = imm;
        @(negedge clk);
        op_valid_i = 1'b0;
        op_i       = 2'd0;
        op_imm_i   = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 reset slot", int'(slot_o), 0);
        chk("R3 reset load mode", int'(load_mode_o), 1);
        chk("R3 reset chan", int'(chan_o), 0);
        chk("R3 reset acc", int'(acc_o), 0);
        rst_n = 1'b1;
        chk("R2 slot0 chan", int'(chan_o), 0);

        // R1 R2: plain rotation after deadstart, table of expected vectors
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R1 rotation slot", int'(slot_o), int'(ROT_VEC[k].slot));
            chk("R2 rotation chan", int'(chan_o), int'(ROT_VEC[k].chan));
        end

        // R6: in load mode slot 0 ignores, slot 2 executes
        issue(0, 2'd1, '0);
        issue(2, 2'd1, '0);
        go_slot(0);
        chk("R6 load-mode pp0 chan kept", int'(chan_o), 0);
        go_slot(2);
        chk("R6 pp2 executes in load mode", int'(chan_o), 3);

        // R3: deadstart mid-run
        go_slot(5);
        deadstart_i = 1'b1;
        @(negedge clk);
        deadstart_i = 1'b0;
        chk("R3 deadstart slot", int'(slot_o), 0);
        chk("R3 deadstart load mode", int'(load_mode_o), 1);
        go_slot(2);
        chk("R3 deadstart restores pp2 chan", int'(chan_o), 2);

        // R7: disconnect ends load mode
        load_disc_i = 1'b1;
        @(negedge clk);
        load_disc_i = 1'b0;
        chk("R7 load mode cleared", int'(load_mode_o), 0);

        // R4 R5: pp0 increments its channel
        issue(0, 2'd1, '0);
        for (int j = 1; j < 10; j++) begin
            chk("R5 other slot chan unchanged", int'(chan_o), j);
            @(negedge clk);
        end
        chk("R4 slot0 drives chan 1", int'(slot_o) * 100 + int'(chan_o), 1);

        // R8 R9: accumulator width on pp3
        issue(3, 2'd3, 12'hFFF);
        issue(3, 2'd3, 12'hFFF);
        go_slot(3);
        chk("R8 add carries above 12 bits", int'(acc_o), 'h1FFE);
        issue(3, 2'd0, '0);
        go_slot(3);
        chk("R9 nop leaves acc", int'(acc_o), 'h1FFE);
        issue(3, 2'd2, '0);
        go_slot(3);
        chk("R9 zero load clears 18 bits", int'(acc_o), 0);
        go_slot(0);
        chk("R5 pp0 chan after others ops", int'(chan_o), 1);

        // R10: channel wrap on pp9
        for (int j = 0; j < 22; j++) issue(9, 2'd1, '0);
        go_slot(9);
        chk("R10 chan at 31", int'(chan_o), 31);
        issue(9, 2'd1, '0);
        go_slot(9);
        chk("R10 chan wraps to 0", int'(chan_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule